// File: doc/BRIEF.md
# Correlated Double Sampling Sequencer

This block runs an external ADC and its analog input multiplexer so that each measurement is a pair of conversions. The first conversion reads the signal input and the second reads the reference input, through the same analog path. The block subtracts the reference result from the signal result. Any offset that the path adds to both conversions cancels in that difference, and low-frequency drift is reduced.

The differences feed a single-pole low-pass filter built from one arithmetic right shift and two saturating adders, so it needs no divider. The filter state restarts from zero for every batch of pairs. After the last pair of a batch, the filtered value appears on the result port together with a one-cycle strobe.

While the enable input stays high, batches follow one another without software involvement. The ADC is seen only through its handshake: a start pulse, a done flag with data, and a stop pulse.

Top module: `cds_seq`

## Requirements
- R1: While rst_n is low, mux_sel, adc_start, adc_stop and result_valid are 0 and result is 0.
- R2: While enable is low and no batch is in progress, adc_start stays 0.
- R3: Within each pair, the first start pulse is issued with mux_sel = 0, which selects the signal input. The second is issued with mux_sel = 1, which selects the reference input. Each batch begins with the signal phase.
- R4: adc_start is a one-cycle pulse. In the cycles directly before it, mux_sel holds its value for at least max(settle_len, 1) cycles.
- R5: adc_data is captured on the cycle in which adc_done is high. adc_stop is high for exactly the following cycle and at no other time.
- R6: The pair difference is signal result minus reference result, computed at 33 bits and clamped to the 32-bit signed range [-2^31, 2^31-1].
- R7: For each pair, acc becomes sat(acc + (sat(cds - acc) >>> 4)). The shift is arithmetic, so negative values keep their sign.
- R8: A batch holds 16 pairs and starts with acc = 0. After the 16th update, result carries the new acc with result_valid high for one cycle. result does not change at any other time.
- R9: If enable is high when a batch ends, the next batch starts without further input. If enable is low, the current batch still completes and the block then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| enable | input | 1 | Run batches while high |
| settle_len | input | 8 | Minimum number of cycles mux_sel must hold before each start pulse |
| mux_sel | output | 1 | Multiplexer select: 0 = signal, 1 = reference |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Conversion finished; adc_data is valid in this cycle |
| adc_data | input | 32 | Signed conversion result |
| adc_stop | output | 1 | One-cycle stop pulse after each capture |
| result | output | 32 | Filtered signed batch result |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with its default parameters: 32-bit data, 16 pairs per batch, shift 4 and an 8-bit settle count. At 32 bits, inputs placed near both ends of the signed range drive the pair difference into its upper and lower clamps. With 16 pairs at shift 4, the accumulator is still visibly short of its target, so any error in the shift or the clear shows in the result. Settle lengths of 0, 4 and 7 are driven through the port; the value 0 exercises the one-cycle minimum hold. Reset is asserted in the middle of a batch to show that the next batch starts clean.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_START  = 3'd2,
    ST_WAIT   = 3'd3,
    ST_STOP   = 3'd4
  } cds_state_e;
endpackage

// File: rtl/cds_sat_addsub.sv
module cds_sat_addsub #(
  parameter int DW  = 32,
  parameter bit SUB = 1'b1
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0] wide;

  if (SUB) begin : g_sub
    assign wide = {a[DW-1], a} - {b[DW-1], b};
  end else begin : g_add
    assign wide = {a[DW-1], a} + {b[DW-1], b};
  end

  always_comb begin
    if (wide[DW] != wide[DW-1]) begin
      y = wide[DW] ? MINV : MAXV;
    end else begin
      y = wide[DW-1:0];
    end
  end
endmodule

// File: rtl/cds_iir.sv
module cds_iir #(
  parameter int DW    = 32,
  parameter int SHIFT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] cds_in,
  output logic [DW-1:0] acc_nxt
);
  logic [DW-1:0]        acc_q;
  logic [DW-1:0]        diff;
  logic signed [DW-1:0] diff_s;
  logic [DW-1:0]        step;

  cds_sat_addsub #(.DW(DW), .SUB(1'b1)) u_diff (
    .a(cds_in), .b(acc_q), .y(diff)
  );

  assign diff_s = diff;
  assign step   = diff_s >>> SHIFT;

  cds_sat_addsub #(.DW(DW), .SUB(1'b0)) u_sum (
    .a(acc_q), .b(step), .y(acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (upd) begin
      acc_q <= acc_nxt;
    end
  end
endmodule

// File: rtl/cds_fsm.sv
module cds_fsm
  import cds_pkg::*;
#(
  parameter int PAIRS = 16,
  parameter int SW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [SW-1:0] settle_len,
  input  logic          adc_done,
  output logic          phase,
  output logic          adc_start,
  output logic          adc_stop,
  output logic          cap_sig,
  output logic          cap_ref,
  output logic          acc_clr,
  output logic          acc_upd,
  output logic          batch_end
);
  localparam int PCW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  cds_state_e     state_q, state_d;
  logic [SW-1:0]  cnt_q, cnt_d;
  logic [PCW-1:0] pair_q, pair_d;
  logic           phase_q, phase_d;
  logic           settle_ok;
  logic           last_pair;

  assign settle_ok = ({1'b0, cnt_q} + (SW+1)'(1)) >= {1'b0, settle_len};
  assign last_pair = (pair_q == PCW'(PAIRS - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pair_d  = pair_q;
    phase_d = phase_q;
    case (state_q)
      ST_IDLE: begin
        if (enable) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
          pair_d  = '0;
          phase_d = 1'b0;
        end
      end
      ST_SETTLE: begin
        if (settle_ok) begin
          state_d = ST_START;
        end else begin
          cnt_d = cnt_q + SW'(1);
        end
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (adc_done) state_d = ST_STOP;
      end
      ST_STOP: begin
        cnt_d = '0;
        if (!phase_q) begin
          phase_d = 1'b1;
          state_d = ST_SETTLE;
        end else if (last_pair) begin
          phase_d = 1'b0;
          state_d = ST_IDLE;
        end else begin
          phase_d = 1'b0;
          pair_d  = pair_q + PCW'(1);
          state_d = ST_SETTLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pair_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pair_q  <= pair_d;
      phase_q <= phase_d;
    end
  end

  assign phase     = phase_q;
  assign adc_start = (state_q == ST_START);
  assign adc_stop  = (state_q == ST_STOP);
  assign cap_sig   = (state_q == ST_WAIT) && adc_done && !phase_q;
  assign cap_ref   = (state_q == ST_WAIT) && adc_done && phase_q;
  assign acc_clr   = (state_q == ST_IDLE) && enable;
  assign acc_upd   = (state_q == ST_STOP) && phase_q;
  assign batch_end = acc_upd && last_pair;
endmodule

// File: rtl/cds_seq.sv
module cds_seq #(
  parameter int DW    = 32,
  parameter int PAIRS = 16,
  parameter int SHIFT = 4,
  parameter int SW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [SW-1:0] settle_len,
  output logic          mux_sel,
  output logic          adc_start,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic          adc_stop,
  output logic [DW-1:0] result,
  output logic          result_valid
);
  logic          cap_sig, cap_ref, acc_clr, acc_upd, batch_end;
  logic [DW-1:0] sig_q, ref_q, cds_w, acc_nxt;
  logic [DW-1:0] result_q;
  logic          valid_q;

  cds_fsm #(.PAIRS(PAIRS), .SW(SW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .settle_len(settle_len),
    .adc_done(adc_done), .phase(mux_sel), .adc_start(adc_start),
    .adc_stop(adc_stop), .cap_sig(cap_sig), .cap_ref(cap_ref),
    .acc_clr(acc_clr), .acc_upd(acc_upd), .batch_end(batch_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (cap_sig) begin
      sig_q <= adc_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (cap_ref) begin
      ref_q <= adc_data;
    end
  end

  cds_sat_addsub #(.DW(DW), .SUB(1'b1)) u_pair_diff (
    .a(sig_q), .b(ref_q), .y(cds_w)
  );

  cds_iir #(.DW(DW), .SHIFT(SHIFT)) u_iir (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .upd(acc_upd),
    .cds_in(cds_w), .acc_nxt(acc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (batch_end) begin
      result_q <= acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= batch_end;
    end
  end

  assign result       = result_q;
  assign result_valid = valid_q;
endmodule

// File: rtl/cds_seq_chk.sv
module cds_seq_chk #(
  parameter int DW = 32,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] settle_len,
  input logic          mux_sel,
  input logic          adc_start,
  input logic          adc_done,
  input logic          adc_stop,
  input logic [DW-1:0] result,
  input logic          result_valid
);
  logic          prev_sel_q;
  logic [SW:0]   run_q;
  logic [SW:0]   hold;

  always_comb begin
    if (mux_sel != prev_sel_q) begin
      hold = '0;
    end else if (&run_q) begin
      hold = run_q;
    end else begin
      hold = run_q + (SW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_q <= 1'b0;
      run_q      <= '0;
    end else begin
      prev_sel_q <= mux_sel;
      run_q      <= hold;
    end
  end

  // R4
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (hold >= {1'b0, settle_len}));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R5
  stop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stop |-> $past(adc_done));

  // R5
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stop |=> !adc_stop);

  // R3
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> $past(adc_stop));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_valid);
endmodule

bind cds_seq cds_seq_chk #(.DW(DW), .SW(SW)) u_chk (.*);

// File: tb/test_cds_seq.sv
module test_cds_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 32;
  localparam int SW  = 8;
  localparam int LAT = 3;
  localparam int NV  = 6;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  // per batch: signal base, reference base, per-pair step
  localparam logic [95:0] VEC [NV] = '{
    {32'sd1000,          32'sd200,    32'sd0},
    {-32'sd5000,         32'sd3000,   32'sd7},
    {32'sh7FFFFFF0,      -32'sd100,   32'sd0},
    {32'sh80000010,      32'sd1000,   32'sd0},
    {32'sd12345,         32'sd12345,  32'sd3},
    {32'sd0,             32'sd0,      32'sd0}
  };

  logic          clk, rst_n, enable;
  logic [SW-1:0] settle_len;
  logic          mux_sel, adc_start, adc_done, adc_stop, result_valid;
  logic [DW-1:0] adc_data, result;

  int n_chk = 0, n_bad = 0;
  int res_cnt = 0, start_cnt = 0, pidx = 0, vidx = 0;
  bit finished = 0;

  cds_seq i_cds_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .settle_len(settle_len),
    .mux_sel(mux_sel), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .adc_stop(adc_stop), .result(result),
    .result_valid(result_valid)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  // ADC model and port monitor, all on the falling edge
  longint macc = 0, sig_m = 0;
  int  hold = 0, pend = 0;
  bit  prev_sel = 0, prev_start = 0, prev_done = 0, prev_valid = 0, exp_phase = 0, psel = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      macc = 0; pidx = 0; exp_phase = 0; pend = 0; hold = 0;
      prev_sel = mux_sel; prev_start = 0; prev_done = 0; prev_valid = 0;
      adc_done = 1'b0; adc_data = '0;
    end else begin
      bit new_done;
      int h;
      logic [95:0] e;
      int d;
      // R5: stop exactly one cycle after done
      if (adc_stop || prev_done) chk(adc_stop == prev_done, "R5", adc_stop, prev_done);
      if (result_valid) begin
        longint act;
        act = longint'($signed(result));
        chk(!prev_valid, "R8", prev_valid, 0);
        chk(pidx == 16, "R8", pidx, 16);
        if ((vidx % NV) == 2 || (vidx % NV) == 3) chk(act == macc, "R6", act, macc);
        else chk(act == macc, "R7", act, macc);
        macc = 0; pidx = 0; vidx++; res_cnt++; exp_phase = 0;
      end
      new_done = 0;
      e = VEC[vidx % NV];
      d = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          new_done = 1;
          if (!psel) begin
            d = int'($signed(e[95:64])) + pidx * int'($signed(e[31:0]));
            sig_m = longint'(d);
          end else begin
            longint cds, diff;
            d = int'($signed(e[63:32])) - pidx * int'($signed(e[31:0]));
            cds  = sat(sig_m - longint'(d));
            diff = sat(cds - macc);
            macc = sat(macc + (diff >>> 4));
            pidx++;
          end
        end
      end
      h = (mux_sel == prev_sel) ? hold + 1 : 0;
      if (adc_start) begin
        chk(!prev_start, "R4", prev_start, 0);
        chk(h >= int'(settle_len), "R4", h, settle_len);
        chk(mux_sel == exp_phase, "R3", mux_sel, exp_phase);
        exp_phase = !exp_phase;
        start_cnt++;
        pend = LAT;
        psel = mux_sel;
      end
      hold = h; prev_sel = mux_sel; prev_start = adc_start;
      prev_valid = result_valid; prev_done = new_done;
      adc_done = new_done;
      adc_data = d;
    end
  end

  task automatic run_batch(input logic [SW-1:0] s);
    int target;
    settle_len = s;
    target = res_cnt + 1;
    enable = 1'b1;
    while (res_cnt < target) begin
      if (pidx >= 12) enable = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    int s0;
    rst_n = 1'b0; enable = 1'b0; settle_len = 8'd4;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mux_sel == 0 && adc_start == 0 && adc_stop == 0, "R1", {mux_sel, adc_start, adc_stop}, 0);
    chk(result_valid == 0 && result == 0, "R1", result, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(start_cnt == 0, "R2", start_cnt, 0);

    // table walk, back-to-back batches with enable held high
    enable = 1'b1;
    for (int i = 0; i < NV; i++) begin
      while (res_cnt <= i) begin
        if (i == NV - 1 && pidx >= 12) enable = 1'b0;
        @(negedge clk);
      end
    end
    chk(res_cnt == NV, "R9", res_cnt, NV);
    s0 = start_cnt;
    repeat (30) @(negedge clk);
    chk(start_cnt == s0, "R9", start_cnt, s0);

    // settle length corners
    run_batch(8'd0);
    run_batch(8'd7);

    // reset in the middle of a batch
    settle_len = 8'd4;
    s0 = start_cnt;
    enable = 1'b1;
    while (start_cnt < s0 + 9) @(negedge clk);
    @(posedge clk); #2 rst_n = 1'b0;
    @(negedge clk);
    chk(mux_sel == 0 && adc_start == 0 && adc_stop == 0, "R1", {mux_sel, adc_start, adc_stop}, 0);
    chk(result_valid == 0 && result == 0, "R1", result, 0);
    @(posedge clk); #2 rst_n = 1'b1; enable = 1'b0;
    @(negedge clk);
    run_batch(8'd4);
    repeat (10) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (40000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", res_cnt, NV + 3);
    finish_up();
  end
endmodule